// File: doc/BRIEF.md
# Immediate-Amount Operand Shifter

This block forms the second ALU operand of a RISC-style core from a register value and a compact operand field. The field carries a shift amount and a shift type. The block produces the shifted value and a shifter carry-out. Left shifts, logical right shifts, arithmetic right shifts and rotates are all supported. An amount of zero does not always mean "leave it alone": for a logical or arithmetic right shift it stands for a shift by the full word width, and for a rotate it selects a one-bit rotate through the incoming carry flag. A set-flags input chooses whether the computed carry is reported as a new flag value or whether the incoming flag is passed through unchanged.

The shifting logic is purely combinational. For test and for pipelined use, it sits behind a single valid/ready register stage. An operand is taken when `in_valid` and `in_ready` are both high at a rising clock edge. Its result is presented on the next cycle with `out_valid` high. The result stays held and stable until `out_ready` is seen high. While a result is held and `out_ready` is low, `in_ready` is low, so the producer sees back-pressure. The stage can accept a new operand in the same cycle that the held result drains, which allows a throughput of one operand per cycle.

Top module: `opshf_unit`

## Requirements
- R1: The shift amount is taken from field bits [11:7] and the shift type from bits [6:5], with type codes 0=left logical, 1=right logical, 2=right arithmetic, 3=rotate right. Field bits [4:0] have no effect.
- R2: With type 0 and amount 0, the result equals the input value and the carry equals the incoming carry.
- R3: With type 1 and amount 0, the result is all zeros and the carry equals input bit 31.
- R4: With type 2 and amount 0, every result bit equals input bit 31, and the carry equals input bit 31.
- R5: With type 3 and amount 0, the result is the input shifted right by one with the incoming carry in bit 31, and the carry equals input bit 0.
- R6: With type 0 and amount n>0, the result is the input shifted left by n and the carry is input bit 32-n.
- R7: With type 1 and amount n>0, the result is the input shifted right by n with zero fill, and the carry is input bit n-1.
- R8: With type 2 and amount n>0, the result is the input shifted right by n with copies of bit 31 filling the top, and the carry is input bit n-1.
- R9: With type 3 and amount n>0, the result is the input rotated right by n, and the carry is input bit n-1.
- R10: `out_carry_valid` equals the captured set-flags input. When set-flags is low, `out_carry` equals the incoming carry.
- R11: An operand is transferred when `in_valid` and `in_ready` are high at a rising edge. Its result appears with `out_valid` high after that edge. `out_valid` falls after a transfer with `out_ready` high and no new operand.
- R12: While `out_valid` is high and `out_ready` is low, `in_ready` is low and the held result and carry do not change.
- R13: During reset and just after it, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Stage can take an operand |
| in_value | input | 32 | Register value to shift |
| in_carry | input | 1 | Current carry flag |
| in_field | input | 12 | Operand field: amount [11:7], type [6:5] |
| in_setflags | input | 1 | Report computed carry as a flag update |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Consumer takes the result |
| out_value | output | 32 | Shifted operand |
| out_carry | output | 1 | Shifter carry-out, or incoming carry when flags are not set |
| out_carry_valid | output | 1 | Carry is a flag update |

## Verification
The bench builds the block with the default 32-bit data width. That gives a 5-bit amount and a 12-bit field, so the extreme amounts 1 and 31 and the zero-amount cases for all four types can be reached directly. A behavioural model built from plain shift operators checks a few hundred random operands with both carry-in values. Back-pressure is tested by holding `out_ready` low while a second operand waits.

// File: rtl/opshf_pkg.sv
package opshf_pkg;

  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } shift_kind_e;

  // Position of the two type bits inside the operand field; the amount
  // follows immediately above them.
  localparam int TYPE_LSB = 5;
  localparam int AMT_LSB  = TYPE_LSB + 2;

endpackage

// File: rtl/opshf_decode.sv
module opshf_decode
  import opshf_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW+1:0]     fld_hi,
  output shift_kind_e       kind,
  output logic [AW-1:0]     amt,
  output logic              amt_zero
);
  // fld_hi is the field from the type bits upward: type in [1:0], amount above.
  always_comb begin
    kind     = shift_kind_e'(fld_hi[1:0]);
    amt      = fld_hi[AW+1:2];
    amt_zero = (fld_hi[AW+1:2] == '0);
  end
endmodule

// File: rtl/opshf_rotator.sv
module opshf_rotator #(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] amt,
  output logic [W-1:0]  dout
);
  logic [W-1:0] stage [AW+1];

  assign stage[0] = din;

  // Logarithmic right-rotate: stage k rotates by 2**k when amt[k] is set.
  for (genvar k = 0; k < AW; k++) begin : g_rot
    localparam int S = 1 << k;
    assign stage[k+1] = amt[k] ? {stage[k][S-1:0], stage[k][W-1:S]} : stage[k];
  end

  assign dout = stage[AW];
endmodule

// File: rtl/opshf_core.sv
module opshf_core
  import opshf_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  x,
  input  logic          cin,
  input  shift_kind_e   kind,
  input  logic [AW-1:0] amt,
  input  logic          amt_zero,
  output logic [W-1:0]  res,
  output logic          cout
);
  localparam logic [W-1:0] ONES = '1;

  logic [AW-1:0] rot_amt;
  logic [W-1:0]  rot;
  logic [W-1:0]  keep_r;
  logic [W-1:0]  keep_l;
  logic          sign;

  // A left shift by n is a right rotate by W-n, i.e. the two's complement of n.
  always_comb begin
    if (kind == SH_LSL) rot_amt = ~amt + AW'(1);
    else                rot_amt = amt;
  end

  opshf_rotator #(.W(W), .AW(AW)) u_rot (
    .din  (x),
    .amt  (rot_amt),
    .dout (rot)
  );

  assign keep_r = ONES >> amt;
  assign keep_l = ONES << amt;
  assign sign   = x[W-1];

  always_comb begin
    res  = x;
    cout = cin;
    unique case (kind)
      SH_LSL: begin
        if (!amt_zero) begin
          res  = rot & keep_l;
          cout = rot[0];          // last bit shifted out of the top
        end
      end
      SH_LSR: begin
        if (amt_zero) begin
          res  = '0;
          cout = sign;
        end else begin
          res  = rot & keep_r;
          cout = rot[W-1];        // last bit shifted out of the bottom
        end
      end
      SH_ASR: begin
        if (amt_zero) begin
          res  = {W{sign}};
          cout = sign;
        end else begin
          res  = (rot & keep_r) | (sign ? ~keep_r : '0);
          cout = rot[W-1];
        end
      end
      SH_ROR: begin
        if (amt_zero) begin
          res  = {cin, x[W-1:1]};
          cout = x[0];
        end else begin
          res  = rot;
          cout = rot[W-1];
        end
      end
      default: begin
        res  = x;
        cout = cin;
      end
    endcase
  end
endmodule

// File: rtl/opshf_hold_stage.sv
module opshf_hold_stage #(
  parameter int PW = 34
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [PW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] out_data
);
  logic          full_q;
  logic [PW-1:0] data_q;

  assign in_ready  = !full_q || out_ready;
  assign out_valid = full_q;
  assign out_data  = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (in_valid && in_ready) begin
      full_q <= 1'b1;
      data_q <= in_data;
    end else if (out_ready) begin
      full_q <= 1'b0;
    end
  end
endmodule

// File: rtl/opshf_unit.sv
module opshf_unit
  import opshf_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int AMT_W   = $clog2(DATA_W),
  parameter int FIELD_W = AMT_LSB + AMT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [DATA_W-1:0]  in_value,
  input  logic               in_carry,
  input  logic [FIELD_W-1:0] in_field,
  input  logic               in_setflags,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [DATA_W-1:0]  out_value,
  output logic               out_carry,
  output logic               out_carry_valid
);
  localparam int PW = DATA_W + 2;

  shift_kind_e         kind;
  logic [AMT_W-1:0]    amt;
  logic                amt_zero;
  logic [DATA_W-1:0]   sh_res;
  logic                sh_cout;
  logic                flag_next;
  logic [PW-1:0]       stage_in;
  logic [PW-1:0]       stage_out;
  logic                unused_low_bits;

  assign unused_low_bits = ^in_field[TYPE_LSB-1:0];

  opshf_decode #(.AW(AMT_W)) u_dec (
    .fld_hi   (in_field[FIELD_W-1:TYPE_LSB]),
    .kind     (kind),
    .amt      (amt),
    .amt_zero (amt_zero)
  );

  opshf_core #(.W(DATA_W), .AW(AMT_W)) u_core (
    .x        (in_value),
    .cin      (in_carry),
    .kind     (kind),
    .amt      (amt),
    .amt_zero (amt_zero),
    .res      (sh_res),
    .cout     (sh_cout)
  );

  // Without set-flags the carry flag keeps its incoming value.
  assign flag_next = in_setflags ? sh_cout : in_carry;
  assign stage_in  = {in_setflags, flag_next, sh_res};

  opshf_hold_stage #(.PW(PW)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (stage_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (stage_out)
  );

  assign out_value       = stage_out[DATA_W-1:0];
  assign out_carry       = stage_out[DATA_W];
  assign out_carry_valid = stage_out[DATA_W+1];
endmodule

// File: rtl/opshf_unit_chk.sv
module opshf_unit_chk
  import opshf_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int AMT_W   = $clog2(DATA_W),
  parameter int FIELD_W = AMT_LSB + AMT_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic [DATA_W-1:0]  in_value,
  input logic               in_carry,
  input logic [FIELD_W-1:0] in_field,
  input logic               in_setflags,
  input logic               out_valid,
  input logic               out_ready,
  input logic [DATA_W-1:0]  out_value,
  input logic               out_carry,
  input logic               out_carry_valid
);
  logic             acc;
  logic [1:0]       typ;
  logic             zamt;

  assign acc  = in_valid && in_ready;
  assign typ  = in_field[TYPE_LSB +: 2];
  assign zamt = (in_field[AMT_LSB +: AMT_W] == '0);

  // R2
  lsl0_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && typ == 2'd0 && zamt |=> out_value == $past(in_value));

  // R3
  lsr0_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && typ == 2'd1 && zamt |=> out_value == '0);

  // R4
  asr0_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && typ == 2'd2 && zamt |=> out_value == {DATA_W{$past(in_value[DATA_W-1])}});

  // R5
  rrx_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && typ == 2'd3 && zamt |=> out_value[DATA_W-1] == $past(in_carry));

  // R10
  noflag_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !in_setflags |=> !out_carry_valid && out_carry == $past(in_carry));

  // R11
  accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  // R12
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_value) && $stable(out_carry)
      && $stable(out_carry_valid));

  // R12
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
endmodule

bind opshf_unit opshf_unit_chk #(
  .DATA_W  (DATA_W),
  .AMT_W   (AMT_W),
  .FIELD_W (FIELD_W)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .in_valid        (in_valid),
  .in_ready        (in_ready),
  .in_value        (in_value),
  .in_carry        (in_carry),
  .in_field        (in_field),
  .in_setflags     (in_setflags),
  .out_valid       (out_valid),
  .out_ready       (out_ready),
  .out_value       (out_value),
  .out_carry       (out_carry),
  .out_carry_valid (out_carry_valid)
);

// File: tb/opshf_unit_test.sv
`timescale 1ns/1ps
module opshf_unit_test;
  localparam int NV = 15;

  // Directed vectors. Field = amount<<7 | type<<5 (R1); low bits are junk on some.
  localparam logic [31:0] V_X [NV] = '{
    32'hA5A5_0F0F, // R2 lsl 0
    32'h8000_0001, // R3 lsr 0
    32'h8000_0001, // R4 asr 0
    32'h7000_0000, // R4 asr 0 positive
    32'h8000_0001, // R5 rrx cin=1
    32'h0000_0002, // R5 rrx cin=0
    32'h8000_0001, // R6 lsl 1
    32'h0000_0003, // R6 lsl 31
    32'h0000_0003, // R7 lsr 1
    32'hC000_0000, // R7 lsr 31
    32'h8000_0010, // R8 asr 4
    32'h1234_5678, // R9 ror 8
    32'h0000_0001, // R9 ror 1
    32'h8000_0001, // R10 lsr 0 without flags
    32'hA5A5_0F0F  // R1 lsl 0 with junk in low field bits
  };
  localparam logic V_C [NV] = '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0};
  localparam logic [11:0] V_F [NV] = '{
    12'h000, 12'h020, 12'h040, 12'h040, 12'h060, 12'h060, 12'h080, 12'hF80,
    12'h0A0, 12'hFA0, 12'h240, 12'h460, 12'h0E0, 12'h020, 12'h01F
  };
  localparam logic V_S [NV] = '{1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1};
  localparam logic [31:0] E_R [NV] = '{
    32'hA5A5_0F0F, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000,
    32'hC000_0000, 32'h0000_0001, 32'h0000_0002, 32'h8000_0000,
    32'h0000_0001, 32'h0000_0001, 32'hF800_0001, 32'h7812_3456,
    32'h8000_0000, 32'h0000_0000, 32'hA5A5_0F0F
  };
  localparam logic E_C [NV] = '{1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0};
  localparam int V_REQ [NV] = '{2,3,4,4,5,5,6,6,7,7,8,9,9,10,1};

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_value;
  logic        in_carry;
  logic [11:0] in_field;
  logic        in_setflags;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_value;
  logic        out_carry;
  logic        out_carry_valid;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  opshf_unit uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_value(in_value), .in_carry(in_carry),
    .in_field(in_field), .in_setflags(in_setflags),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_value(out_value), .out_carry(out_carry),
    .out_carry_valid(out_carry_valid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Behavioural model from plain operators: returns {carry, result}.
  function automatic logic [32:0] model(input logic [31:0] x, input logic c,
                                        input logic [11:0] f, input logic sf);
    int n;
    logic [31:0] r;
    logic        co;
    n = int'(f[11:7]);
    case (f[6:5])
      2'd0: begin r = (n == 0) ? x : x << n; co = (n == 0) ? c : x[32-n]; end
      2'd1: begin r = (n == 0) ? 32'h0 : x >> n; co = (n == 0) ? x[31] : x[n-1]; end
      2'd2: begin r = (n == 0) ? {32{x[31]}} : 32'($signed(x) >>> n);
                  co = (n == 0) ? x[31] : x[n-1]; end
      default: begin
        r  = (n == 0) ? {c, x[31:1]} : ((x >> n) | (x << (32 - n)));
        co = (n == 0) ? x[0] : x[n-1];
      end
    endcase
    return {sf ? co : c, r};
  endfunction

  task automatic drive(input logic [31:0] x, input logic c, input logic [11:0] f, input logic sf);
    in_value    = x;
    in_carry    = c;
    in_field    = f;
    in_setflags = sf;
    in_valid    = 1'b1;
  endtask

  // Present one operand, let it be taken, and leave outputs to sample at the next negedge.
  task automatic send(input logic [31:0] x, input logic c, input logic [11:0] f, input logic sf);
    @(negedge clk);
    drive(x, c, f, sf);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [32:0] m;
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    in_value = '0; in_carry = 1'b0; in_field = '0; in_setflags = 1'b0;
    repeat (3) @(negedge clk);
    // R13: reset state
    check("R13", 32'(out_valid), 32'd0);
    check("R13", 32'(in_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R13", 32'(out_valid), 32'd0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      send(V_X[i], V_C[i], V_F[i], V_S[i]);
      check($sformatf("R%0d value #%0d", V_REQ[i], i), out_value, E_R[i]);
      check($sformatf("R%0d carry #%0d", V_REQ[i], i), 32'(out_carry), 32'(E_C[i]));
      check($sformatf("R10 flagvalid #%0d", i), 32'(out_carry_valid), 32'(V_S[i]));
      check($sformatf("R11 valid #%0d", i), 32'(out_valid), 32'd1);
    end

    // Random operands against the model, covering R6 R7 R8 R9 and both carries
    for (int i = 0; i < 300; i++) begin
      logic [31:0] x;
      logic [11:0] f;
      logic c, sf;
      x  = $urandom;
      f  = 12'($urandom);
      c  = 1'($urandom);
      sf = 1'($urandom);
      m  = model(x, c, f, sf);
      send(x, c, f, sf);
      check("R6-9 random value", out_value, m[31:0]);
      check("R10 random carry", 32'(out_carry), 32'(m[32]));
    end

    // R11: valid drops when drained with nothing new
    @(negedge clk);
    check("R11 drain", 32'(out_valid), 32'd0);

    // R12: back-pressure
    out_ready = 1'b0;
    send(32'h1234_5678, 1'b1, 12'h460, 1'b1);
    check("R12 first", out_value, 32'h7812_3456);
    drive(32'h8000_0001, 1'b0, 12'h040, 1'b1);
    repeat (2) begin
      @(negedge clk);
      check("R12 ready low", 32'(in_ready), 32'd0);
      check("R12 held value", out_value, 32'h7812_3456);
      check("R12 held carry", 32'(out_carry), 32'd0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    // R11: second operand taken in the same cycle the first drained
    check("R11 next value", out_value, 32'hFFFF_FFFF);
    check("R11 next carry", 32'(out_carry), 32'd1);
    check("R11 next valid", 32'(out_valid), 32'd1);
    @(negedge clk);
    check("R11 empty", 32'(out_valid), 32'd0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule